// File: doc/BRIEF.md
# Scoreboard Function-Unit Dependency Matrix

This block tracks register hazards between the function units of an out-of-order core. Each unit owns one row of state. When an instruction is placed on a unit, the row notes the registers it will read, the register it will write, and which other busy units it must wait for. Hazards are found through one single-bit wire per register and per unit rather than through a tag lookup. A register column is simply the set of units that still write it, or the set that still have to read it. From the rows the block drives two independent grants per unit: permission to fetch operands and permission to write the result. Conflicting units therefore hold each other back cell by cell, with no global stall.

Speculation is handled by branch rows. While a branch row is open, every unit placed on a unit row is marked as shadowed by it. A shadowed unit may read and execute, but its write grant stays low. Committing the branch lifts the shadow. Cancelling it discards every unit it shadows in a single cycle and reports those units on a kill output.

The issue logic offers one instruction per cycle. The units answer with read-done and write-done strobes, and the branch logic sends one open, commit or cancel command per cycle.

Top module: `sbm_dep_matrix`

## Requirements
- R1: After reset, and after any reset applied while work is in flight, every unit is idle: fu_busy, go_rd, go_wr and fu_kill are all zero.
- R2: iss_ok is high in the same cycle exactly when iss_valid is high and unit iss_fu is not busy. An accepted unit shows fu_busy from the next cycle on. A refused issue changes nothing.
- R3: Read-after-write: a unit whose source register (iss_src1 or iss_src2) is the destination of another busy unit keeps go_rd low until that writer's write completes.
- R4: The read grant does not depend on the write grant: a unit with no pending writer of its sources gets go_rd even while its own write is held back.
- R5: Write-after-read: a unit's go_wr stays low while a unit issued earlier still has an unread source equal to its destination.
- R6: Write-after-write: a unit's go_wr stays low while a unit issued earlier still has the same destination pending.
- R7: go_wr needs the unit's own operands to have been read. A write completes when wr_done is high together with go_wr, and the unit is idle from the next cycle.
- R8: rd_done or wr_done given while the matching grant is low has no effect.
- R9: br_op encodes 0 = none, 1 = open, 2 = commit, 3 = cancel, acting on branch row br_id. A unit issued while a branch row is open gets no go_wr until that row is committed.
- R10: Cancelling an open branch row raises fu_kill in that cycle for every busy unit it shadows. Those units are idle from the next cycle. Commit or cancel of a row that is not open has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_fu | input | FW | Target unit index |
| iss_src1 | input | RW | First source register |
| iss_src2 | input | RW | Second source register |
| iss_dst | input | RW | Destination register |
| iss_ok | output | 1 | Issue accepted this cycle |
| rd_done | input | NFU | Per-unit operands-read strobe |
| wr_done | input | NFU | Per-unit result-written strobe |
| br_op | input | 2 | Branch row command (0 none, 1 open, 2 commit, 3 cancel) |
| br_id | input | BW | Branch row index |
| go_rd | output | NFU | Per-unit read grant |
| go_wr | output | NFU | Per-unit write grant |
| fu_busy | output | NFU | Per-unit busy |
| fu_kill | output | NFU | Per-unit cancel pulse |

## Verification
The assertions check on every cycle that grants appear only on busy units, that no unit holds both grants, that an accepted issue, a completed write and a kill each move fu_busy the expected way one cycle later, and that a fired read grant drops. Which unit waits on which, and the order in which hazards release, depends on the history of register numbers. Only the bench's scenarios can show this: the read-after-write, write-after-read and write-after-write chains, the shadow that holds back a write after its read is done, and the commit and cancel sequences.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {
    BR_NONE   = 2'd0,
    BR_OPEN   = 2'd1,
    BR_COMMIT = 2'd2,
    BR_CANCEL = 2'd3
  } br_op_e;
endpackage

// File: rtl/sbm_branch_rows.sv
module sbm_branch_rows #(
  parameter int NBR = 2,
  localparam int BW = (NBR > 1) ? $clog2(NBR) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     br_op,
  input  logic [BW-1:0]  br_id,
  output logic [NBR-1:0] br_act,
  output logic [NBR-1:0] br_commit,
  output logic [NBR-1:0] br_cancel
);
  import sbm_pkg::*;

  br_op_e         op;
  logic [NBR-1:0] id_oh;
  logic [NBR-1:0] open_oh;
  logic [NBR-1:0] act_q;

  assign op = br_op_e'(br_op);

  always_comb begin
    id_oh = '0;
    id_oh[br_id] = 1'b1;
  end

  assign open_oh   = (op == BR_OPEN)   ? id_oh : '0;
  assign br_commit = (op == BR_COMMIT) ? (id_oh & act_q) : '0;
  assign br_cancel = (op == BR_CANCEL) ? (id_oh & act_q) : '0;
  assign br_act    = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= (act_q | open_oh) & ~br_commit & ~br_cancel;
  end
endmodule

// File: rtl/sbm_fu_row.sv
module sbm_fu_row #(
  parameter int NFU  = 4,
  parameter int NREG = 8,
  parameter int NBR  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [NREG-1:0] iss_src_oh,
  input  logic [NREG-1:0] iss_dst_oh,
  input  logic [NFU-1:0]  iss_raw,
  input  logic [NFU-1:0]  iss_war,
  input  logic [NFU-1:0]  iss_waw,
  input  logic [NBR-1:0]  iss_shadow,
  input  logic [NFU-1:0]  rd_fire_all,
  input  logic [NFU-1:0]  gone_all,
  input  logic [NBR-1:0]  br_commit,
  input  logic [NBR-1:0]  br_cancel,
  input  logic            rd_done_in,
  input  logic            wr_done_in,
  output logic            busy,
  output logic            go_rd,
  output logic            go_wr,
  output logic            kill,
  output logic            rd_fire,
  output logic            wr_fire,
  output logic [NREG-1:0] dst_oh,
  output logic [NREG-1:0] unread_oh
);
  logic            busy_q, read_q;
  logic [NREG-1:0] dst_q, src_q;
  logic [NFU-1:0]  raw_q, war_q, waw_q;
  logic [NBR-1:0]  shd_q;

  assign busy      = busy_q;
  assign kill      = busy_q & |(shd_q & br_cancel);
  assign go_rd     = busy_q & ~read_q & ~|raw_q;
  assign go_wr     = busy_q & read_q & ~|war_q & ~|waw_q & ~|shd_q;
  assign rd_fire   = go_rd & rd_done_in;
  assign wr_fire   = go_wr & wr_done_in;
  assign dst_oh    = busy_q ? dst_q : '0;
  assign unread_oh = (busy_q && !read_q) ? src_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; read_q <= 1'b0;
      dst_q  <= '0;   src_q  <= '0;
      raw_q  <= '0;   war_q  <= '0;   waw_q <= '0;
      shd_q  <= '0;
    end else if (issue) begin
      busy_q <= 1'b1;       read_q <= 1'b0;
      dst_q  <= iss_dst_oh; src_q  <= iss_src_oh;
      raw_q  <= iss_raw;    war_q  <= iss_war;    waw_q <= iss_waw;
      shd_q  <= iss_shadow;
    end else if (wr_fire || kill) begin
      busy_q <= 1'b0; read_q <= 1'b0;
      dst_q  <= '0;   src_q  <= '0;
      raw_q  <= '0;   war_q  <= '0;   waw_q <= '0;
      shd_q  <= '0;
    end else begin
      read_q <= read_q | rd_fire;
      raw_q  <= raw_q & ~gone_all;
      waw_q  <= waw_q & ~gone_all;
      war_q  <= war_q & ~(rd_fire_all | gone_all);
      shd_q  <= shd_q & ~br_commit;
    end
  end
endmodule

// File: rtl/sbm_dep_matrix.sv
module sbm_dep_matrix #(
  parameter int NFU  = 4,
  parameter int NREG = 8,
  parameter int NBR  = 2,
  localparam int FW  = $clog2(NFU),
  localparam int RW  = $clog2(NREG),
  localparam int BW  = (NBR > 1) ? $clog2(NBR) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_valid,
  input  logic [FW-1:0]  iss_fu,
  input  logic [RW-1:0]  iss_src1,
  input  logic [RW-1:0]  iss_src2,
  input  logic [RW-1:0]  iss_dst,
  output logic           iss_ok,
  input  logic [NFU-1:0] rd_done,
  input  logic [NFU-1:0] wr_done,
  input  logic [1:0]     br_op,
  input  logic [BW-1:0]  br_id,
  output logic [NFU-1:0] go_rd,
  output logic [NFU-1:0] go_wr,
  output logic [NFU-1:0] fu_busy,
  output logic [NFU-1:0] fu_kill
);
  function automatic logic [NREG-1:0] reg_onehot(input logic [RW-1:0] r);
    logic [NREG-1:0] v;
    v = '0;
    v[r] = 1'b1;
    return v;
  endfunction

  function automatic logic [NFU-1:0] fu_onehot(input logic [FW-1:0] f);
    logic [NFU-1:0] v;
    v = '0;
    v[f] = 1'b1;
    return v;
  endfunction

  // named events, also observed by the checker
  logic [NFU-1:0]  rd_fire, wr_fire, gone;
  logic [NBR-1:0]  br_act, br_commit, br_cancel;
  logic [NREG-1:0] row_dst [NFU];
  logic [NREG-1:0] row_src [NFU];
  logic [NFU-1:0]  wr_col  [NREG];
  logic [NFU-1:0]  rd_col  [NREG];
  logic [NFU-1:0]  iss_raw, iss_war, iss_waw, issue_row;
  logic [NBR-1:0]  iss_shadow;
  logic [NREG-1:0] src_oh, dst_oh;

  sbm_branch_rows #(.NBR(NBR)) u_br (
    .clk(clk), .rst_n(rst_n), .br_op(br_op), .br_id(br_id),
    .br_act(br_act), .br_commit(br_commit), .br_cancel(br_cancel)
  );

  // per-register column wires: which units write / still read each register
  for (genvar r = 0; r < NREG; r++) begin : g_col
    for (genvar j = 0; j < NFU; j++) begin : g_cell
      assign wr_col[r][j] = row_dst[j][r];
      assign rd_col[r][j] = row_src[j][r];
    end
  end

  assign gone       = wr_fire | fu_kill;
  assign src_oh     = reg_onehot(iss_src1) | reg_onehot(iss_src2);
  assign dst_oh     = reg_onehot(iss_dst);
  assign iss_raw    = (wr_col[iss_src1] | wr_col[iss_src2]) & ~gone;
  assign iss_waw    = wr_col[iss_dst] & ~gone;
  assign iss_war    = rd_col[iss_dst] & ~rd_fire & ~gone;
  assign iss_shadow = br_act & ~br_commit & ~br_cancel;
  assign iss_ok     = iss_valid & ~fu_busy[iss_fu];
  assign issue_row  = iss_ok ? fu_onehot(iss_fu) : '0;

  for (genvar i = 0; i < NFU; i++) begin : g_row
    sbm_fu_row #(.NFU(NFU), .NREG(NREG), .NBR(NBR)) u_row (
      .clk(clk), .rst_n(rst_n),
      .issue(issue_row[i]),
      .iss_src_oh(src_oh), .iss_dst_oh(dst_oh),
      .iss_raw(iss_raw), .iss_war(iss_war), .iss_waw(iss_waw),
      .iss_shadow(iss_shadow),
      .rd_fire_all(rd_fire), .gone_all(gone),
      .br_commit(br_commit), .br_cancel(br_cancel),
      .rd_done_in(rd_done[i]), .wr_done_in(wr_done[i]),
      .busy(fu_busy[i]), .go_rd(go_rd[i]), .go_wr(go_wr[i]),
      .kill(fu_kill[i]), .rd_fire(rd_fire[i]), .wr_fire(wr_fire[i]),
      .dst_oh(row_dst[i]), .unread_oh(row_src[i])
    );
  end
endmodule

// File: rtl/sbm_dep_matrix_chk.sv
module sbm_dep_matrix_chk #(
  parameter int NFU = 4,
  localparam int FW = $clog2(NFU)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           iss_ok,
  input logic [FW-1:0]  iss_fu,
  input logic [NFU-1:0] go_rd,
  input logic [NFU-1:0] go_wr,
  input logic [NFU-1:0] fu_busy,
  input logic [NFU-1:0] fu_kill,
  input logic [NFU-1:0] rd_fire,
  input logic [NFU-1:0] wr_fire
);
  for (genvar i = 0; i < NFU; i++) begin : g_u
    // R1
    grant_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_rd[i] || go_wr[i]) |-> fu_busy[i]);
    // R2
    issue_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_ok && iss_fu == FW'(i)) |-> !fu_busy[i]);
    // R2
    issue_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_ok && iss_fu == FW'(i)) |=> fu_busy[i]);
    // R7
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(go_rd[i] && go_wr[i]));
    // R7
    write_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire[i] |=> !fu_busy[i]);
    // R8
    read_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire[i] |=> !go_rd[i]);
    // R10
    kill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fu_kill[i] |-> (fu_busy[i] && !go_wr[i]));
    // R10
    kill_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fu_kill[i] |=> !fu_busy[i]);
  end
endmodule

bind sbm_dep_matrix sbm_dep_matrix_chk #(.NFU(NFU)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_ok(iss_ok), .iss_fu(iss_fu),
  .go_rd(go_rd), .go_wr(go_wr), .fu_busy(fu_busy), .fu_kill(fu_kill),
  .rd_fire(rd_fire), .wr_fire(wr_fire)
);

// File: tb/sim_sbm_dep_matrix.sv
`timescale 1ns/1ps
module sim_sbm_dep_matrix;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_valid = 1'b0;
  logic [1:0] iss_fu = '0;
  logic [2:0] iss_src1 = '0, iss_src2 = '0, iss_dst = '0;
  logic       iss_ok;
  logic [3:0] rd_done = '0, wr_done = '0;
  logic [1:0] br_op = '0;
  logic       br_id = 1'b0;
  logic [3:0] go_rd, go_wr, fu_busy, fu_kill;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sbm_dep_matrix #(.NFU(4), .NREG(8), .NBR(2)) u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_fu(iss_fu),
    .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_dst(iss_dst),
    .iss_ok(iss_ok), .rd_done(rd_done), .wr_done(wr_done),
    .br_op(br_op), .br_id(br_id), .go_rd(go_rd), .go_wr(go_wr),
    .fu_busy(fu_busy), .fu_kill(fu_kill)
  );

  typedef struct packed {
    logic       v;
    logic [1:0] fu;
    logic [2:0] s1, s2, d;
    logic [3:0] rdd, wrd;
    logic [1:0] bop;
    logic       bid;
    logic       e_ok;
    logic [3:0] e_rd, e_wr, e_busy, e_kill;
  } vec_t;

  // v fu s1 s2 d rdd wrd bop bid | ok go_rd go_wr busy kill
  localparam vec_t TBL [31] = '{
    '{0,0,0,0,0,4'h0,4'h0,0,0, 0,4'h0,4'h0,4'h0,4'h0}, // idle
    '{1,0,1,2,3,4'h0,4'h0,0,0, 1,4'h0,4'h0,4'h0,4'h0}, // R2 u0 r1,r2->r3
    '{1,1,3,4,5,4'h0,4'h0,0,0, 1,4'h1,4'h0,4'h1,4'h0}, // R3 u1 reads r3
    '{1,2,6,6,1,4'h2,4'h0,0,0, 1,4'h1,4'h0,4'h3,4'h0}, // R5 u2 writes r1; R8 u1 rd ignored
    '{0,0,0,0,0,4'h5,4'h0,0,0, 0,4'h5,4'h0,4'h7,4'h0}, // R4 reads u0,u2
    '{0,0,0,0,0,4'h0,4'h0,0,0, 0,4'h0,4'h5,4'h7,4'h0}, // R5 war lifted
    '{0,0,0,0,0,4'h0,4'h1,0,0, 0,4'h0,4'h5,4'h7,4'h0}, // R7 u0 writes
    '{1,2,0,0,7,4'h0,4'h0,0,0, 0,4'h2,4'h4,4'h6,4'h0}, // R2 refused; R3 u1 free; R8
    '{0,0,0,0,0,4'h0,4'h0,1,0, 0,4'h2,4'h4,4'h6,4'h0}, // R9 open b0
    '{1,3,0,0,7,4'h0,4'h0,0,0, 1,4'h2,4'h4,4'h6,4'h0}, // R9 u3 shadowed
    '{0,0,0,0,0,4'h8,4'h0,0,0, 0,4'hA,4'h4,4'hE,4'h0}, // R4 shadowed unit reads
    '{0,0,0,0,0,4'h0,4'h0,0,0, 0,4'h2,4'h4,4'hE,4'h0}, // R9 u3 write held
    '{0,0,0,0,0,4'h0,4'h0,2,0, 0,4'h2,4'h4,4'hE,4'h0}, // R9 commit b0
    '{0,0,0,0,0,4'h0,4'h0,0,0, 0,4'h2,4'hC,4'hE,4'h0}, // R9 u3 released
    '{0,0,0,0,0,4'h0,4'hC,0,0, 0,4'h2,4'hC,4'hE,4'h0}, // R7 u2,u3 write
    '{0,0,0,0,0,4'h0,4'h0,1,1, 0,4'h2,4'h0,4'h2,4'h0}, // R9 open b1
    '{1,0,5,5,2,4'h0,4'h0,0,0, 1,4'h2,4'h0,4'h2,4'h0}, // R3 u0 on u1
    '{1,3,2,0,4,4'h1,4'h0,0,0, 1,4'h2,4'h0,4'h3,4'h0}, // R5 u3; R8 u0 rd ignored
    '{0,0,0,0,0,4'h0,4'h0,3,1, 0,4'h2,4'h0,4'hB,4'h9}, // R10 cancel b1
    '{0,0,0,0,0,4'h0,4'h0,0,0, 0,4'h2,4'h0,4'h2,4'h0}, // R10 killed idle
    '{0,0,0,0,0,4'h2,4'h0,0,0, 0,4'h2,4'h0,4'h2,4'h0}, // R4 u1 reads
    '{0,0,0,0,0,4'h0,4'h2,0,0, 0,4'h0,4'h2,4'h2,4'h0}, // R7 u1 writes
    '{0,0,0,0,0,4'h0,4'h0,0,0, 0,4'h0,4'h0,4'h0,4'h0}, // R7 empty
    '{1,0,0,0,6,4'h0,4'h0,0,0, 1,4'h0,4'h0,4'h0,4'h0}, // R6 u0 -> r6
    '{1,1,0,0,6,4'h0,4'h0,0,0, 1,4'h1,4'h0,4'h1,4'h0}, // R6 u1 -> r6
    '{0,0,0,0,0,4'h3,4'h0,0,0, 0,4'h3,4'h0,4'h3,4'h0}, // R4 both read
    '{0,0,0,0,0,4'h0,4'h0,0,0, 0,4'h0,4'h1,4'h3,4'h0}, // R6 u1 held
    '{0,0,0,0,0,4'h0,4'h3,0,0, 0,4'h0,4'h1,4'h3,4'h0}, // R8 u1 wr ignored
    '{0,0,0,0,0,4'h0,4'h0,0,0, 0,4'h0,4'h2,4'h2,4'h0}, // R6 u1 released
    '{0,0,0,0,0,4'h0,4'h2,0,0, 0,4'h0,4'h2,4'h2,4'h0}, // R7
    '{0,0,0,0,0,4'h0,4'h0,0,0, 0,4'h0,4'h0,4'h0,4'h0}  // R7
  };

  task automatic chk(input string what, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    iss_valid = 1'b0; iss_fu = '0; iss_src1 = '0; iss_src2 = '0; iss_dst = '0;
    rd_done = '0; wr_done = '0; br_op = '0; br_id = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset busy", fu_busy, 4'h0);
    chk("R1 reset go_rd", go_rd, 4'h0);
    chk("R1 reset go_wr", go_wr, 4'h0);
    chk("R1 reset kill", fu_kill, 4'h0);

    for (int k = 0; k < 31; k++) begin
      @(negedge clk);
      iss_valid = TBL[k].v;  iss_fu = TBL[k].fu;
      iss_src1 = TBL[k].s1;  iss_src2 = TBL[k].s2; iss_dst = TBL[k].d;
      rd_done = TBL[k].rdd;  wr_done = TBL[k].wrd;
      br_op = TBL[k].bop;    br_id = TBL[k].bid;
      #1;
      chk($sformatf("R2 row %0d iss_ok", k), {3'b0, iss_ok}, {3'b0, TBL[k].e_ok});
      chk($sformatf("R3/R4 row %0d go_rd", k), go_rd, TBL[k].e_rd);
      chk($sformatf("R5/R6/R9 row %0d go_wr", k), go_wr, TBL[k].e_wr);
      chk($sformatf("R7 row %0d busy", k), fu_busy, TBL[k].e_busy);
      chk($sformatf("R10 row %0d kill", k), fu_kill, TBL[k].e_kill);
    end

    // R10: cancel of a row that is not open has no effect
    @(negedge clk); idle_inputs();
    iss_valid = 1'b1; iss_fu = 2'd0; iss_src1 = 3'd1; iss_src2 = 3'd1; iss_dst = 3'd2;
    @(negedge clk); idle_inputs();
    br_op = 2'd3; br_id = 1'b0;
    #1;
    chk("R10 idle cancel kill", fu_kill, 4'h0);
    @(negedge clk); idle_inputs(); #1;
    chk("R10 idle cancel busy", fu_busy, 4'h1);
    chk("R10 idle cancel go_rd", go_rd, 4'h1);

    // R1: reset while work is in flight
    iss_valid = 1'b1; iss_fu = 2'd2; iss_src1 = 3'd2; iss_src2 = 3'd2; iss_dst = 3'd3;
    @(negedge clk); idle_inputs(); #1;
    chk("R1 before reset busy", fu_busy, 4'h5);
    rst_n = 1'b0;
    @(negedge clk); #1;
    chk("R1 in reset busy", fu_busy, 4'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 after reset busy", fu_busy, 4'h0);
    chk("R1 after reset go_rd", go_rd, 4'h0);
    chk("R1 after reset go_wr", go_wr, 4'h0);

    finish_run();
  end
endmodule